// File: doc/BRIEF.md
# T1 Receive Channel Code Substitution

This block sits in the receive data path of a T1 framer, after frame alignment. It sees the received frame one channel byte at a time: a valid strobe, a start-of-frame flag on the first byte, a channel number from 1 to 24, and the byte itself. Each channel has its own enable bit in a 24-bit mark mask. When a channel's bit is set, the block replaces that byte with a substitute code. When the bit is clear, the byte goes through untouched. Every result appears on a registered output one clock after its input.

There are two substitute codes. The first is a constant idle byte. The second is an eight-byte digital milliwatt sequence that stands for a 1 kHz tone and moves forward by one byte per frame. A single select input chooses between them for all marked channels. The mask is written through a small register port as three bytes.

The block takes a new mask and select value only at a start of frame. A channel is therefore never replaced for part of a frame.

Top module: `t1_chan_subst`

## Requirements
- R1: After reset, out_valid is 0, all three mask bytes read back as 0x00, and the tone index is 0, so the first frame after reset uses tone byte 0x1E.
- R2: out_valid is in_valid delayed by exactly one clock. Each out_data value belongs to the input byte accepted on the clock before it.
- R3: An input byte whose channel mask bit is 0 appears unchanged on out_data.
- R4: A marked channel outputs the idle byte 0x7F when pattern_sel is 0.
- R5: A marked channel outputs the tone byte for the frame when pattern_sel is 1. The tone sequence is 0x1E, 0x0B, 0x0B, 0x1E, 0x9E, 0x8B, 0x8B, 0x9E. The index moves up by one at every start of frame, whichever code is selected, and wraps from 7 to 0. All marked channels in one frame get the same tone byte.
- R6: Mask layout: address 0x2D holds channels 1–8, 0x2E holds channels 9–16 and 0x2F holds channels 17–24. Within each byte, bit 0 is the lowest-numbered channel and bit 7 the highest.
- R7: A write to any address other than 0x2D–0x2F changes no mask bit. A read of 0x2D–0x2F returns the stored byte, and a read of any other address returns 0x00.
- R8: The mask and pattern_sel are sampled only on a beat that has in_valid and in_sof both high. That beat and the rest of its frame use the sampled values, even if either one changes in the middle of the frame.
- R9: A byte whose channel number is 0 or 25–31 passes through unchanged, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address for reads and writes |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Combinational read data for cfg_addr |
| pattern_sel | input | 1 | Substitute code: 0 for idle byte, 1 for milliwatt tone |
| in_valid | input | 1 | Input channel byte is valid |
| in_sof | input | 1 | This byte is the first of a frame |
| in_chan | input | 5 | Channel number, 1 to 24 |
| in_data | input | 8 | Received channel byte |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Channel byte after substitution |

## Verification
Some properties are checked by assertions on every clock:
- the one-cycle valid delay;
- pass-through of unmarked and out-of-range channels;
- the idle byte on marked channels;
- the tone index, which holds between frame starts and steps by one at each start;
- the frame-held mask, which does not change inside a frame;
- ignored out-of-range writes.

Other behaviour only shows up across a scenario, so only the bench can check it:
- the order of the tone sequence over many frames, including the wrap back to the first byte;
- the bit-to-channel layout of the three mask bytes;
- a mask or select change in the middle of a frame taking effect only at the next frame.

// File: rtl/t1sub_pkg.sv
// Shared constants and the milliwatt tone table for the channel substitution block.
// Assumes byte-wide channel data and an eight-entry tone sequence.
package t1sub_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned TONE_LEN = 8;
    localparam int unsigned TONE_IW  = $clog2(TONE_LEN);
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'h7F;

    // Returns the tone byte for a given position in the eight-byte sequence.
    function automatic logic [BYTE_W-1:0] tone_byte(input logic [TONE_IW-1:0] idx);
        case (idx)
            3'd0:    tone_byte = 8'h1E;
            3'd1:    tone_byte = 8'h0B;
            3'd2:    tone_byte = 8'h0B;
            3'd3:    tone_byte = 8'h1E;
            3'd4:    tone_byte = 8'h9E;
            3'd5:    tone_byte = 8'h8B;
            3'd6:    tone_byte = 8'h8B;
            default: tone_byte = 8'h9E;
        endcase
    endfunction
endpackage

// File: rtl/t1sub_mask_regs.sv
// Mask register file: N_REG byte registers at consecutive addresses starting at BASE_ADDR.
// Register k holds channels 8k+1 to 8k+8, with the lower channel in the lower bit.
// Writes to other addresses are dropped. Reads are combinational and return 0 outside the range.
module t1sub_mask_regs #(
    parameter int unsigned N_REG     = 3,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 8'h2D
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic [N_REG*8-1:0]   mask_flat
);
    logic [7:0] regs [N_REG];
    logic       in_range;

    // Flags an address that falls inside the register window.
    always_comb begin
        in_range = 1'b0;
        for (int k = 0; k < N_REG; k++) begin
            if (addr == ADDR_W'(BASE_ADDR + k)) in_range = 1'b1;
        end
    end

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        // Stores one mask byte when its own address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   regs[g] <= '0;
            else if (wr && addr == ADDR_W'(BASE_ADDR + g)) regs[g] <= wdata;
        end
        assign mask_flat[g*8 +: 8] = regs[g];
    end

    // Selects the read byte for the current address.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_REG; k++) begin
            if (addr == ADDR_W'(BASE_ADDR + k)) rdata = regs[k];
        end
    end

    // R7
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !in_range |=> $stable(mask_flat));
endmodule

// File: rtl/t1sub_frame_ctl.sv
// Frame control: on each start-of-frame beat it latches the mask and select for the
// whole frame and steps the tone index. The outputs give the settings that apply to
// the current beat: the just-sampled values on the start beat, the held values after it.
module t1sub_frame_ctl #(
    parameter int unsigned N_CH = 24,
    parameter int unsigned IW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof_beat,
    input  logic [N_CH-1:0] new_mask,
    input  logic            new_sel,
    output logic [N_CH-1:0] eff_mask,
    output logic            eff_sel,
    output logic [IW-1:0]   eff_idx
);
    logic [N_CH-1:0] act_mask;
    logic            act_sel;
    logic [IW-1:0]   frame_idx;
    logic [IW-1:0]   next_idx;

    // Latches the per-frame settings and steps the tone index at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mask  <= '0;
            act_sel   <= 1'b0;
            frame_idx <= '0;
            next_idx  <= '0;
        end else if (sof_beat) begin
            act_mask  <= new_mask;
            act_sel   <= new_sel;
            frame_idx <= next_idx;
            next_idx  <= next_idx + 1'b1;
        end
    end

    // Chooses the settings for the current beat.
    always_comb begin
        eff_mask = sof_beat ? new_mask : act_mask;
        eff_sel  = sof_beat ? new_sel  : act_sel;
        eff_idx  = sof_beat ? next_idx : frame_idx;
    end

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_beat |=> $stable(next_idx));
    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_beat |=> next_idx == IW'($past(next_idx) + 1'b1));
    // R8
    mask_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_beat |=> $stable(act_mask) && $stable(act_sel));
endmodule

// File: rtl/t1_chan_subst.sv
// T1 receive channel code substitution, top level. Each valid byte is replaced by the
// idle byte or the frame's tone byte when its channel is marked, and otherwise passes
// through. The result is registered, so it appears one clock later.
// Assumes in_sof is high only on a valid beat that starts a frame.
module t1_chan_subst
    import t1sub_pkg::*;
#(
    parameter int unsigned N_CH      = 24,
    parameter int unsigned CHAN_W    = 5,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 8'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              pattern_sel,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    output logic [7:0]        out_data
);
    localparam int unsigned N_REG = (N_CH + 7) / 8;

    logic [N_REG*8-1:0] mask_flat;
    logic [N_CH-1:0]    eff_mask;
    logic               eff_sel;
    logic [TONE_IW-1:0] eff_idx;
    logic               sof_beat;
    logic               mark_hit;
    logic               chan_ok;
    logic [7:0]         sub_byte;

    assign sof_beat = in_valid && in_sof;

    t1sub_mask_regs #(
        .N_REG(N_REG), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .mask_flat(mask_flat)
    );

    t1sub_frame_ctl #(
        .N_CH(N_CH), .IW(TONE_IW)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .sof_beat(sof_beat),
        .new_mask(mask_flat[N_CH-1:0]), .new_sel(pattern_sel),
        .eff_mask(eff_mask), .eff_sel(eff_sel), .eff_idx(eff_idx)
    );

    // Finds the mask bit for the current channel number; out-of-range numbers never hit.
    always_comb begin
        mark_hit = 1'b0;
        chan_ok  = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (in_chan == CHAN_W'(i + 1)) begin
                mark_hit = eff_mask[i];
                chan_ok  = 1'b1;
            end
        end
    end

    // Picks the substitute code for a marked channel.
    assign sub_byte = eff_sel ? tone_byte(eff_idx) : IDLE_BYTE;

    // Registers the output byte and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= mark_hit ? sub_byte : in_data;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !mark_hit |=> out_data == $past(in_data));
    // R4
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mark_hit && !eff_sel |=> out_data == IDLE_BYTE);
    // R9
    bad_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !chan_ok |=> out_data == $past(in_data));
endmodule

// File: tb/t1_chan_subst_tb.sv
// Scoreboard bench: the driver computes each expected byte from the requirements and
// pushes it to a queue; the monitor pops and compares on every valid output.
module t1_chan_subst_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       pattern_sel = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [4:0] in_chan = '0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic [7:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0]  exp_q[$];
    string       tag_q[$];

    // Model state, kept from the requirements only.
    logic [7:0]  m_regs [3] = '{8'h00, 8'h00, 8'h00};
    logic [23:0] m_act = '0;
    logic        m_act_sel = 1'b0;
    logic [2:0]  m_cnt = '0;
    logic [2:0]  m_fidx = '0;
    logic [7:0]  tone [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};

    always #2 clk = ~clk;

    t1_chan_subst u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pattern_sel(pattern_sel),
        .in_valid(in_valid), .in_sof(in_sof), .in_chan(in_chan), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 50000", cyc);
            finish_run();
        end
    end

    // Monitor: pops and compares each valid output byte.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected out_valid", 8'h01, 8'h00);
            end else begin
                check(tag_q.pop_front(), out_data, exp_q.pop_front());
            end
        end
    end

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a >= 8'h2D && a <= 8'h2F) m_regs[a - 8'h2D] = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic check_read(input string req, input logic [7:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic send_beat(input logic sof, input logic [4:0] ch, input logic [7:0] d,
                             input string req);
        logic       hit;
        logic [7:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_chan = ch; in_data = d;
        if (sof) begin
            m_act = {m_regs[2], m_regs[1], m_regs[0]};
            m_act_sel = pattern_sel;
            m_fidx = m_cnt;
            m_cnt = m_cnt + 3'd1;
        end
        hit = (ch >= 5'd1 && ch <= 5'd24) ? m_act[ch - 5'd1] : 1'b0;
        e = hit ? (m_act_sel ? tone[m_fidx] : 8'h7F) : d;
        exp_q.push_back(e);
        tag_q.push_back($sformatf("%s ch%0d", req, ch));
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] seed, input string req);
        for (int c = 1; c <= 24; c++) begin
            send_beat(c == 1, 5'(c), seed + 8'(c * 7), req);
        end
        go_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out_valid", {7'd0, out_valid}, 8'h00);
        check_read("R1 mask 2D", 8'h2D, 8'h00);
        check_read("R1 mask 2E", 8'h2E, 8'h00);
        check_read("R1 mask 2F", 8'h2F, 8'h00);

        // R3 nothing marked: frame passes through (tone index now moves to 1)
        send_frame(8'h10, "R3");

        // R6 layout and R7 readback
        do_write(8'h2D, 8'h01);
        do_write(8'h2E, 8'h80);
        do_write(8'h2F, 8'h80);
        check_read("R7 read 2D", 8'h2D, 8'h01);
        check_read("R7 read 2E", 8'h2E, 8'h80);
        check_read("R7 read 2F", 8'h2F, 8'h80);
        // R7 writes outside window ignored
        do_write(8'h2C, 8'hFF);
        do_write(8'h30, 8'hFF);
        check_read("R7 read 2C", 8'h2C, 8'h00);
        check_read("R7 read 2D kept", 8'h2D, 8'h01);
        check_read("R7 read 2F kept", 8'h2F, 8'h80);

        // R4 idle code on ch1, ch16, ch24; R6 others pass
        pattern_sel = 1'b0;
        send_frame(8'h20, "R4/R6");

        // R9 out-of-range channels with an all-marked mask
        do_write(8'h2D, 8'hFF);
        do_write(8'h2E, 8'hFF);
        do_write(8'h2F, 8'hFF);
        send_beat(1'b1, 5'd1, 8'h55, "R4 sof");
        send_beat(1'b0, 5'd0, 8'hA1, "R9 ch0");
        send_beat(1'b0, 5'd25, 8'hA2, "R9 ch25");
        send_beat(1'b0, 5'd31, 8'hA3, "R9 ch31");
        send_beat(1'b0, 5'd24, 8'hA4, "R4 ch24");
        go_idle();

        // R5 tone over ten frames, wrapping the index
        do_write(8'h2D, 8'h5A);
        do_write(8'h2E, 8'h00);
        do_write(8'h2F, 8'h81);
        pattern_sel = 1'b1;
        for (int f = 0; f < 10; f++) send_frame(8'(f * 16), "R5");

        // R8 mid-frame changes apply only at next frame
        for (int c = 1; c <= 12; c++) send_beat(c == 1, 5'(c), 8'(c + 8'h40), "R8 old");
        go_idle();
        pattern_sel = 1'b0;
        do_write(8'h2D, 8'hA5);
        do_write(8'h2E, 8'hFF);
        for (int c = 13; c <= 24; c++) send_beat(1'b0, 5'(c), 8'(c + 8'h40), "R8 old");
        go_idle();
        send_frame(8'h33, "R8 new");

        // R2 gaps produce no output
        repeat (3) @(negedge clk);
        check("R2 out_valid in gap", {7'd0, out_valid}, 8'h00);
        check("R2 queue drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule